// File: doc/BRIEF.md
# Bidirectional Dynamic Shifter with Flag Exchange

This block is a 32-bit shift and rotate unit for an integer execution pipeline. It offers two dynamic shifts, a logical one and an arithmetic one, whose direction and distance both come from a signed count operand. A clear sign bit selects a left shift by the low five count bits. A set sign bit selects a right shift by the two's-complement negation of those five bits. A set sign bit with low bits of zero is a special full-width right shift.

It also offers single-bit shifts and rotates that exchange one bit with a one-bit flag, called T, and fixed logical shifts of 2, 8 and 16 places in either direction. The caller presents the operand, the count, a 4-bit operation code and the current T each cycle. The result and the new T appear from a register stage one clock later.

Top module: `dyn_shifter`

## Requirements
- R1: While `rst_n` is low, `result` and `t_out` are 0. Otherwise both outputs are registered and reflect the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R2: For op 0 (logical dynamic) and op 1 (arithmetic dynamic), a count with bit 31 clear shifts the operand left by count[4:0] with zero fill. Count bits 30..5 have no effect.
- R3: For ops 0 and 1, a count with bit 31 set and count[4:0] nonzero shifts right by 32 minus count[4:0], which equals (~count[4:0] & 31) + 1. Op 0 fills with zeros and op 1 fills with copies of operand bit 31.
- R4: For op 0, a count with bit 31 set and count[4:0] equal to zero gives a result of 0.
- R5: For op 1, a count with bit 31 set and count[4:0] equal to zero gives all 32 bits equal to operand bit 31.
- R6: Op 2 (rotate left through T) puts operand bit 31 into `t_out` and shifts `t_in` into result bit 0.
- R7: Op 3 (rotate right through T) puts operand bit 0 into `t_out` and shifts `t_in` into result bit 31.
- R8: Op 4 (single-bit arithmetic left) shifts left by one with a 0 into bit 0 and puts operand bit 31 into `t_out`.
- R9: Op 5 (single-bit arithmetic right) keeps bit 31 and op 6 (single-bit logical right) inserts 0 into bit 31. Both put operand bit 0 into `t_out`.
- R10: Ops 7, 8 and 9 shift left by 2, 8 and 16, and ops 10, 11 and 12 shift right by 2, 8 and 16. All of them use zero fill and set `t_out` equal to `t_in`.
- R11: The dynamic ops 0 and 1 set `t_out` equal to `t_in`. Op codes 13 to 15 pass the operand to `result` unchanged and set `t_out` equal to `t_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand | input | 32 | Value to shift or rotate |
| count | input | 32 | Signed shift count for ops 0 and 1 |
| op | input | 4 | Operation code |
| t_in | input | 1 | Current T flag |
| result | output | 32 | Registered shifted value |
| t_out | output | 1 | Registered new T flag |

## Verification
Every result and every new T flag is due one rising edge after its inputs are applied. The bench drives the inputs on a falling edge and compares the outputs at the next falling edge, after exactly one capturing edge. A directed test samples the outputs just before that edge to confirm the old value still holds. A second directed test checks that reset clears both outputs at once, without waiting for a clock edge.

// File: rtl/dyn_shifter.sv
module dyn_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] count,
  input  logic [3:0]   op,
  input  logic         t_in,
  output logic [W-1:0] result,
  output logic         t_out
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_DLOG = 4'd0;
  localparam logic [3:0] OP_DARI = 4'd1;
  localparam logic [3:0] OP_ROTL = 4'd2;
  localparam logic [3:0] OP_ROTR = 4'd3;
  localparam logic [3:0] OP_SHAL = 4'd4;
  localparam logic [3:0] OP_SHAR = 4'd5;
  localparam logic [3:0] OP_SHLR = 4'd6;
  localparam logic [3:0] OP_SL2  = 4'd7;
  localparam logic [3:0] OP_SL8  = 4'd8;
  localparam logic [3:0] OP_SL16 = 4'd9;
  localparam logic [3:0] OP_SR2  = 4'd10;
  localparam logic [3:0] OP_SR8  = 4'd11;
  localparam logic [3:0] OP_SR16 = 4'd12;

  wire          neg  = count[W-1];
  wire [SW-1:0] amt  = count[SW-1:0];
  wire [SW-1:0] ramt = ~amt + SW'(1);
  wire          sgn  = operand[W-1];

  logic unused_cnt;
  assign unused_cnt = ^count[W-2:SW];

  logic [W-1:0] dyn_log, dyn_ari;
  always_comb begin
    if (!neg) begin
      dyn_log = operand << amt;
      dyn_ari = operand << amt;
    end else if (amt == '0) begin
      dyn_log = '0;
      dyn_ari = {W{sgn}};
    end else begin
      dyn_log = operand >> ramt;
      dyn_ari = W'($signed(operand) >>> ramt);
    end
  end

  logic [W-1:0] nxt_res;
  logic         nxt_t;
  always_comb begin
    nxt_res = operand;
    nxt_t   = t_in;
    case (op)
      OP_DLOG: nxt_res = dyn_log;
      OP_DARI: nxt_res = dyn_ari;
      OP_ROTL: begin nxt_res = {operand[W-2:0], t_in}; nxt_t = sgn; end
      OP_ROTR: begin nxt_res = {t_in, operand[W-1:1]}; nxt_t = operand[0]; end
      OP_SHAL: begin nxt_res = {operand[W-2:0], 1'b0}; nxt_t = sgn; end
      OP_SHAR: begin nxt_res = {sgn, operand[W-1:1]};  nxt_t = operand[0]; end
      OP_SHLR: begin nxt_res = {1'b0, operand[W-1:1]}; nxt_t = operand[0]; end
      OP_SL2:  nxt_res = operand << 2;
      OP_SL8:  nxt_res = operand << 8;
      OP_SL16: nxt_res = operand << 16;
      OP_SR2:  nxt_res = operand >> 2;
      OP_SR8:  nxt_res = operand >> 8;
      OP_SR16: nxt_res = operand >> 16;
      default: ;
    endcase
  end

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      t_out  <= 1'b0;
      live   <= 1'b0;
    end else begin
      result <= nxt_res;
      t_out  <= nxt_t;
      live   <= 1'b1;
    end
  end

  // R2
  a_r2_dyn_left: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op) <= OP_DARI && !$past(count[W-1]))
      |-> result == ($past(operand) << $past(count[SW-1:0])));
  // R4
  a_r4_log_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op) == OP_DLOG && $past(count[W-1]) && $past(count[SW-1:0]) == '0)
      |-> result == '0);
  // R5
  a_r5_ari_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op) == OP_DARI && $past(count[W-1]) && $past(count[SW-1:0]) == '0)
      |-> result == {W{$past(operand[W-1])}});
  // R6
  a_r6_rotl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op) == OP_ROTL)
      |-> (t_out == $past(operand[W-1]) && result[0] == $past(t_in)));
  // R7
  a_r7_rotr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op) == OP_ROTR)
      |-> (t_out == $past(operand[0]) && result[W-1] == $past(t_in)));
  // R9
  a_r9_right_one: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ($past(op) == OP_SHAR || $past(op) == OP_SHLR))
      |-> (t_out == $past(operand[0]) &&
           result[W-1] == ($past(op) == OP_SHAR && $past(operand[W-1]))));
  // R10 and R11
  a_r10_t_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ($past(op) <= OP_DARI || $past(op) >= OP_SL2))
      |-> t_out == $past(t_in));
endmodule

// File: tb/dyn_shifter_test.sv
module dyn_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] count = '0;
  logic [3:0]  op = '0;
  logic        t_in = 1'b0;
  logic [31:0] result;
  logic        t_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_shifter #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .count(count),
    .op(op), .t_in(t_in), .result(result), .t_out(t_out)
  );

  // fields: op, operand, count, t_in, expected result, expected t, requirement
  localparam logic [105:0] VEC [NV] = '{
    {4'd0,  32'h0000_00F1, 32'h0000_0004, 1'b1, 32'h0000_0F10, 1'b1, 4'd2},  // R2
    {4'd0,  32'h8000_0001, 32'h0000_0021, 1'b0, 32'h0000_0002, 1'b0, 4'd2},  // R2 high count bits ignored
    {4'd0,  32'h0000_0003, 32'h0000_001F, 1'b0, 32'h8000_0000, 1'b0, 4'd2},  // R2
    {4'd1,  32'h0000_0003, 32'h0000_001E, 1'b1, 32'hC000_0000, 1'b1, 4'd2},  // R2
    {4'd0,  32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'h4000_0000, 1'b0, 4'd3},  // R3
    {4'd1,  32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 32'hC000_0000, 1'b1, 4'd3},  // R3
    {4'd1,  32'hF000_0000, 32'h8000_0001, 1'b0, 32'hFFFF_FFFF, 1'b0, 4'd3},  // R3
    {4'd0,  32'hF000_0000, 32'h8000_0001, 1'b0, 32'h0000_0001, 1'b0, 4'd3},  // R3
    {4'd0,  32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1, 4'd4},  // R4
    {4'd0,  32'h1234_5678, 32'hFFFF_FFE0, 1'b0, 32'h0000_0000, 1'b0, 4'd4},  // R4
    {4'd1,  32'h8000_1234, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b0, 4'd5},  // R5
    {4'd1,  32'h7FFF_FFFF, 32'hFFFF_FFE0, 1'b1, 32'h0000_0000, 1'b1, 4'd5},  // R5
    {4'd2,  32'h8000_0001, 32'h0000_0000, 1'b0, 32'h0000_0002, 1'b1, 4'd6},  // R6
    {4'd2,  32'h4000_0000, 32'h0000_0000, 1'b1, 32'h8000_0001, 1'b0, 4'd6},  // R6
    {4'd3,  32'h0000_0001, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 4'd7},  // R7
    {4'd3,  32'h0000_0002, 32'h0000_0000, 1'b1, 32'h8000_0001, 1'b0, 4'd7},  // R7
    {4'd4,  32'hC000_0001, 32'h0000_0000, 1'b0, 32'h8000_0002, 1'b1, 4'd8},  // R8
    {4'd4,  32'h4000_0000, 32'h0000_0000, 1'b1, 32'h8000_0000, 1'b0, 4'd8},  // R8
    {4'd5,  32'h8000_0003, 32'h0000_0000, 1'b0, 32'hC000_0001, 1'b1, 4'd9},  // R9
    {4'd6,  32'h8000_0003, 32'h0000_0000, 1'b0, 32'h4000_0001, 1'b1, 4'd9},  // R9
    {4'd6,  32'h0000_0002, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0, 4'd9},  // R9
    {4'd7,  32'hC000_0001, 32'h0000_0000, 1'b1, 32'h0000_0004, 1'b1, 4'd10}, // R10
    {4'd8,  32'h1234_5678, 32'h0000_0000, 1'b0, 32'h3456_7800, 1'b0, 4'd10}, // R10
    {4'd9,  32'h1234_5678, 32'h0000_0000, 1'b1, 32'h5678_0000, 1'b1, 4'd10}, // R10
    {4'd10, 32'h8000_0007, 32'h0000_0000, 1'b0, 32'h2000_0001, 1'b0, 4'd10}, // R10
    {4'd11, 32'h1234_5678, 32'h0000_0000, 1'b1, 32'h0012_3456, 1'b1, 4'd10}, // R10
    {4'd12, 32'h8765_4321, 32'h0000_0000, 1'b0, 32'h0000_8765, 1'b0, 4'd10}, // R10
    {4'd13, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 32'hDEAD_BEEF, 1'b1, 4'd11}, // R11
    {4'd15, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0000_0001, 1'b0, 4'd11}  // R11
  };

  task automatic check(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic got_t, input logic exp_t);
    checks++;
    if (got_r !== exp_r || got_t !== exp_t) begin
      failures++;
      $display("FAIL %s result=%h t=%b expected result=%h t=%b", tag, got_r, got_t, exp_r, exp_t);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", result, 32'h0, t_out, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op      = VEC[i][105:102];
      operand = VEC[i][101:70];
      count   = VEC[i][69:38];
      t_in    = VEC[i][37];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), result, VEC[i][36:5], t_out, VEC[i][4]);
    end

    // R1: one-cycle latency, old value holds until the capturing edge
    op = 4'd13; operand = 32'hAAAA_0001; t_in = 1'b0;
    @(negedge clk);
    op = 4'd13; operand = 32'h5555_0002; t_in = 1'b1;
    @(posedge clk);
    #1;
    check("R1 latency after edge", result, 32'h5555_0002, t_out, 1'b1);
    op = 4'd2; operand = 32'h8000_0000; t_in = 1'b0;
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    check("R1 latency before edge", result, 32'h5555_0002, t_out, 1'b1);
    @(negedge clk);
    check("R6 after latency test", result, 32'h0000_0000, t_out, 1'b1);

    // R1: asynchronous clear mid-run
    op = 4'd13; operand = 32'hFFFF_FFFF; t_in = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async reset", result, 32'h0, t_out, 1'b0);
    @(negedge clk);
    check("R1 held in reset", result, 32'h0, t_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset release", result, 32'hFFFF_FFFF, t_out, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule